// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block produces one pulse-width modulated output from an 8-bit counter. A simple write port sets the period, the duty, the counter and a control byte. The counter advances only on cycles when the selected tick input is high. Those tick inputs come from a prescaler outside the block. The output is at the programmed polarity level while the counter is below the duty value, and at the opposite level otherwise.

Period and duty writes first go to a buffer. While the channel runs, the buffer is copied into the active value only at three safe points: when the current period ends, when the counter is written, or while the channel is disabled. This way a running waveform is always the complete old shape or the complete new shape. Two counting modes are offered. Left-aligned mode repeats every `period` ticks. Center-aligned mode counts up and then down, and repeats every `2*period` ticks.

Register map, selected by `wr_addr` / `rd_addr`:
- 0: control byte. Bit 0 enables the channel. Bit 1 selects center alignment. Bit 2 is the polarity (1 means the active level is high). Bits 4:3 select the index into `tick_in`.
- 1: period.
- 2: duty.
- 3: counter.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: After reset the counter reads 0, the period and duty read 0, the control byte is 0 and `pwm_out` is 1 (the inactive level for polarity 0).
- R2: While the channel is enabled, a write to the period (address 1) or the duty (address 2) changes only the buffer. The waveform keeps its active values until the next load point.
- R3: The buffered period and duty move to the active values when a period ends, when the counter is written, or in any cycle the channel is disabled. If a write to a buffer happens in the same cycle as a load, the newly written value is the one loaded.
- R4: While the channel is disabled (control bit 0 = 0), a period or duty write updates the buffer and the active value at the same clock edge.
- R5: A write of any value to the counter (address 3) sets it to 0 at the next edge and restarts counting in the upward direction.
- R6: In left-aligned mode (control bit 1 = 0) with period P > 0, the counter steps 0, 1, …, P-1 and then returns to 0, one step per selected tick.
- R7: In center-aligned mode (control bit 1 = 1) with period P > 0, the counter steps up from 0 to P and then down to 1 before returning to 0, giving 2P ticks per period.
- R8: While enabled, `pwm_out` equals the polarity bit (control bit 2) when the counter is below the active duty, and its inverse otherwise. The output register adds one cycle of latency.
- R9: An active period of 0 holds `pwm_out` at the inactive level. An active duty equal to or above a nonzero period holds it at the active level.
- R10: The counter changes only in cycles where `tick_in[ctrl[4:3]]` is 1 and the channel is enabled. While the channel is disabled, the counter holds and `pwm_out` is the inverse of the polarity bit.
- R11: A read of the period or duty returns the last value written, even when that value is not yet active. A read of the counter returns its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_in | input | NUM_TICKS (4) | Prescaled count-enable pulses, one chosen by control bits 4:3 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W (8) | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W (8) | Combinational read data |
| pwm_out | output | 1 | Registered PWM output |
| cnt_out | output | CNT_W (8) | Current counter value |

## Verification
The waveform is first run with a tick on every cycle in both alignment modes and both polarities. This separates off-by-one errors at the wrap and turn-around points from errors in the tick gating. Period and duty are then changed while the channel runs, and the counter is written and the channel disabled while an update is still buffered. These cases show whether loads happen only at the three legal points, and whether a write in the same cycle as a load wins. Boundary values (period 0, duty 0, and duty at or above the period) show whether the constant-level cases are handled. A long phase with random ticks, tick selects and writes compares counter and output against the model on every cycle, including mode switches in the middle of a period.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_PER  = 2'd1,
    REG_DUTY = 2'd2,
    REG_CNT  = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CTR_BIT  = 1;
  localparam int CTRL_POL_BIT  = 2;
  localparam int CTRL_TSEL_LSB = 3;

endpackage

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int TSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              load,
  output logic [CNT_W-1:0]  ctrl_word,
  output logic              ctrl_en,
  output logic              ctrl_center,
  output logic              ctrl_pol,
  output logic [TSEL_W-1:0] ctrl_tsel,
  output logic [CNT_W-1:0]  per_buf,
  output logic [CNT_W-1:0]  duty_buf,
  output logic [CNT_W-1:0]  per_act,
  output logic [CNT_W-1:0]  duty_act
);

  localparam int NSLOT = 2;

  logic [CNT_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0] buf_q [NSLOT];
  logic [CNT_W-1:0] buf_d [NSLOT];
  logic [CNT_W-1:0] act_q [NSLOT];
  logic [CNT_W-1:0] act_d [NSLOT];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && (wr_addr == REG_CTRL)) ctrl_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_slot
      localparam logic [1:0] SLOT_ADDR = 2'(int'(REG_PER) + g);
      logic slot_wr;

      always_comb begin
        slot_wr  = wr_en && (wr_addr == SLOT_ADDR);
        buf_d[g] = slot_wr ? wr_data : buf_q[g];
        act_d[g] = act_q[g];
        if (load) act_d[g] = slot_wr ? wr_data : buf_q[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          buf_q[g] <= '0;
          act_q[g] <= '0;
        end else begin
          buf_q[g] <= buf_d[g];
          act_q[g] <= act_d[g];
        end
      end
    end
  endgenerate

  assign ctrl_word   = ctrl_q;
  assign ctrl_en     = ctrl_q[CTRL_EN_BIT];
  assign ctrl_center = ctrl_q[CTRL_CTR_BIT];
  assign ctrl_pol    = ctrl_q[CTRL_POL_BIT];
  assign ctrl_tsel   = ctrl_q[CTRL_TSEL_LSB +: TSEL_W];
  assign per_buf     = buf_q[0];
  assign duty_buf    = buf_q[1];
  assign per_act     = act_q[0];
  assign duty_act    = act_q[1];

endmodule

// File: rtl/pwm_dbuf_counter.sv
module pwm_dbuf_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             center,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] per,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  localparam logic [CNT_W:0]   EXT_ONE = (CNT_W+1)'(1);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;
  logic [CNT_W:0]   cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + EXT_ONE;
    cnt_d   = cnt_q;
    up_d    = up_q;
    wrap    = 1'b0;
    if (clr) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (en && tick) begin
      if (!center) begin
        up_d = 1'b1;
        if (cnt_inc >= {1'b0, per}) begin
          cnt_d = '0;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else if (up_q && (cnt_q < per)) begin
        cnt_d = cnt_q + ONE;
      end else if (cnt_q <= ONE) begin
        cnt_d = '0;
        up_d  = 1'b1;
        wrap  = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
        up_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/pwm_dbuf_wave.sv
module pwm_dbuf_wave #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pol,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm_out
);

  logic active;
  logic out_d, out_q;

  always_comb begin
    active = (per != '0) && ((duty >= per) || (cnt < duty));
    if (en) out_d = pol ? active : ~active;
    else    out_d = ~pol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b1;
    else        out_q <= out_d;
  end

  assign pwm_out = out_q;

endmodule

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int NUM_TICKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TICKS-1:0] tick_in,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic [1:0]           rd_addr,
  output logic [CNT_W-1:0]     rd_data,
  output logic                 pwm_out,
  output logic [CNT_W-1:0]     cnt_out
);

  localparam int TSEL_W = (NUM_TICKS > 1) ? $clog2(NUM_TICKS) : 1;

  logic [1:0]        rst_sync_q;
  logic              rst_n_sync;
  logic [CNT_W-1:0]  ctrl_word;
  logic              ctrl_en, ctrl_center, ctrl_pol;
  logic [TSEL_W-1:0] ctrl_tsel;
  logic [CNT_W-1:0]  per_buf, duty_buf, per_act, duty_act;
  logic [CNT_W-1:0]  cnt;
  logic              wrap, tick, cnt_clr, load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_TICKS; i++) begin
      if (ctrl_tsel == TSEL_W'(i)) tick = tick_in[i];
    end
  end

  assign cnt_clr = wr_en && (wr_addr == REG_CNT);
  assign load    = ~ctrl_en | cnt_clr | wrap;

  pwm_dbuf_regs #(.CNT_W(CNT_W), .TSEL_W(TSEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n_sync),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .load(load),
    .ctrl_word(ctrl_word), .ctrl_en(ctrl_en), .ctrl_center(ctrl_center),
    .ctrl_pol(ctrl_pol), .ctrl_tsel(ctrl_tsel),
    .per_buf(per_buf), .duty_buf(duty_buf),
    .per_act(per_act), .duty_act(duty_act)
  );

  pwm_dbuf_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_sync),
    .en(ctrl_en), .center(ctrl_center), .tick(tick), .clr(cnt_clr),
    .per(per_act), .cnt(cnt), .wrap(wrap)
  );

  pwm_dbuf_wave #(.CNT_W(CNT_W)) u_wave (
    .clk(clk), .rst_n(rst_n_sync),
    .en(ctrl_en), .pol(ctrl_pol), .cnt(cnt),
    .per(per_act), .duty(duty_act), .pwm_out(pwm_out)
  );

  always_comb begin
    unique case (rd_addr)
      REG_CTRL: rd_data = ctrl_word;
      REG_PER:  rd_data = per_buf;
      REG_DUTY: rd_data = duty_buf;
      default:  rd_data = cnt;
    endcase
  end

  assign cnt_out = cnt;

endmodule

// File: rtl/pwm_dbuf_chk.sv
module pwm_dbuf_chk
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n_sync,
  input logic             en,
  input logic             pol,
  input logic             tick,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic             load,
  input logic [CNT_W-1:0] per_act,
  input logic [CNT_W-1:0] cnt,
  input logic             pwm_out
);

  // R2: an enabled period write outside a load point leaves the active period alone
  p_defer_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (en && wr_en && (wr_addr == REG_PER) && !load) |=> $stable(per_act));

  // R4: a disabled period write reaches the active period at once
  p_direct_write_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!en && wr_en && (wr_addr == REG_PER)) |=> (per_act == $past(wr_data)));

  // R5: a counter write clears the counter
  p_cnt_clear_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_en && (wr_addr == REG_CNT)) |=> (cnt == '0));

  // R9: a zero active period gives the inactive level
  p_zero_per_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (en && (per_act == '0)) |=> (pwm_out == !$past(pol)));

  // R10: no tick and no clear means the counter holds
  p_tick_gate_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!tick && !(wr_en && (wr_addr == REG_CNT))) |=> $stable(cnt));

  // R10: disabled channel holds its counter and idles the output
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!en && !(wr_en && (wr_addr == REG_CNT))) |=> $stable(cnt));

  p_idle_out_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !en |=> (pwm_out == !$past(pol)));

endmodule

bind pwm_dbuf_channel pwm_dbuf_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n_sync(rst_n_sync), .en(ctrl_en), .pol(ctrl_pol),
  .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .load(load), .per_act(per_act), .cnt(cnt), .pwm_out(pwm_out)
);

// File: tb/pwm_dbuf_channel_bench.sv
`timescale 1ns/1ps
module pwm_dbuf_channel_bench;

  localparam int W  = 8;
  localparam int NT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] tick_in = '1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [1:0]    rd_addr = '0;
  logic [W-1:0]  rd_data;
  logic          pwm_out;
  logic [W-1:0]  cnt_out;

  pwm_dbuf_channel u_pwm_dbuf_channel (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .pwm_out(pwm_out), .cnt_out(cnt_out)
  );

  always #4 clk = ~clk;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    cmp_on   = 1'b0;
  bit    done     = 1'b0;
  int    tick_mode = 0;   // 0: all high, 1: random, 2: all low
  string cur_req  = "R1";

  // reference model state
  int m_ctrl, m_pbuf, m_pact, m_dbuf, m_dact, m_cnt;
  bit m_up, m_out;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_pbuf = 0; m_pact = 0; m_dbuf = 0; m_dact = 0;
      m_cnt = 0; m_up = 1; m_out = 1;
    end else begin
      bit en, ctr, pol, act, tk, cwr, wrp, ld, pw, dw, nup;
      int ncnt;
      en  = m_ctrl[0]; ctr = m_ctrl[1]; pol = m_ctrl[2];
      act = (m_pact != 0) && ((m_dact >= m_pact) || (m_cnt < m_dact));
      tk  = tick_in[(m_ctrl >> 3) & 3];
      cwr = wr_en && (wr_addr == 3);
      pw  = wr_en && (wr_addr == 1);
      dw  = wr_en && (wr_addr == 2);
      ncnt = m_cnt; nup = m_up; wrp = 0;
      if (cwr) begin ncnt = 0; nup = 1; end
      else if (en && tk) begin
        if (!ctr) begin
          nup = 1;
          if (m_cnt + 1 >= m_pact) begin ncnt = 0; wrp = 1; end
          else ncnt = m_cnt + 1;
        end else if (m_up && m_cnt < m_pact) ncnt = m_cnt + 1;
        else if (m_cnt <= 1) begin ncnt = 0; nup = 1; wrp = 1; end
        else begin ncnt = m_cnt - 1; nup = 0; end
      end
      ld = !en || cwr || wrp;
      if (ld) begin
        m_pact = pw ? int'(wr_data) : m_pbuf;
        m_dact = dw ? int'(wr_data) : m_dbuf;
      end
      if (pw) m_pbuf = int'(wr_data);
      if (dw) m_dbuf = int'(wr_data);
      if (wr_en && wr_addr == 0) m_ctrl = int'(wr_data);
      m_out = en ? (pol ? act : !act) : !pol;
      m_cnt = ncnt; m_up = nup;
    end
  end

  always @(negedge clk) begin
    if (tick_mode == 1)      tick_in <= NT'($urandom);
    else if (tick_mode == 2) tick_in <= '0;
    else                     tick_in <= '1;
    if (cmp_on) begin
      n_checks++;
      if (pwm_out !== m_out) begin
        n_fails++;
        $display("FAIL %s pwm_out: got %0b exp %0b at %0t", cur_req, pwm_out, m_out, $time);
      end
      n_checks++;
      if (int'(cnt_out) != m_cnt) begin
        n_fails++;
        $display("FAIL %s cnt_out: got %0d exp %0d at %0t", cur_req, cnt_out, m_cnt, $time);
      end
    end
  end

  task automatic check_val(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s value: got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_check(input string req, input int a, input int exp);
    rd_addr = 2'(a);
    #1;
    check_val(req, int'(rd_data), exp);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: got timeout exp completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1: reset state
    cur_req = "R1";
    check_val("R1", int'(cnt_out), 0);
    check_val("R1", int'(pwm_out), 1);
    rd_check("R1", 1, 0);
    rd_check("R1", 2, 0);
    rd_check("R1", 0, 0);
    cmp_on = 1'b1;

    // R4: writes while disabled
    cur_req = "R4";
    wr(1, 5); wr(2, 2);
    // R6 / R8: left aligned, active high
    cur_req = "R6";
    wr(0, 8'h05);
    idle(30);
    // R2 / R11: buffered period update while running
    cur_req = "R2";
    wr(1, 8);
    rd_check("R11", 1, 8);
    wr(2, 6);
    rd_check("R11", 2, 6);
    idle(40);
    // R8: active-low polarity
    cur_req = "R8";
    wr(0, 8'h01);
    idle(30);
    // R7: center aligned
    cur_req = "R7";
    wr(0, 8'h07);
    idle(50);
    // R5: counter write mid-period, with a pending update
    cur_req = "R5";
    wr(1, 4);
    idle(3);
    wr(3, 8'hA5);
    rd_check("R11", 3, m_cnt);
    idle(30);
    // R3: disable with pending update, then re-enable
    cur_req = "R3";
    wr(0, 8'h05);
    idle(2);
    wr(1, 10);
    idle(2);
    wr(0, 8'h04);
    idle(5);
    wr(0, 8'h05);
    idle(40);
    // R9: duty above period, duty zero, period zero
    cur_req = "R9";
    wr(2, 8'hFF);
    idle(30);
    wr(2, 0);
    idle(30);
    wr(0, 8'h04);
    wr(1, 0);
    wr(0, 8'h05);
    idle(20);
    // R10: tick gating and select, disabled hold
    cur_req = "R10";
    wr(1, 6); wr(2, 3);
    wr(0, 8'h15);
    tick_mode = 1;
    idle(60);
    tick_mode = 2;
    idle(10);
    tick_mode = 1;
    wr(0, 8'h14);
    idle(20);
    // random stress across all rules
    cur_req = "R3";
    wr(0, 8'h05);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 9) == 0) begin
        int a;
        int d;
        a = $urandom_range(0, 3);
        case (a)
          0: d = int'($urandom_range(0, 31)) | (($urandom_range(0, 5) != 0) ? 1 : 0);
          1: d = $urandom_range(0, 12);
          2: d = $urandom_range(0, 14);
          default: d = $urandom_range(0, 255);
        endcase
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
      end
    end
    tick_mode = 0;
    idle(5);
    cmp_on = 1'b0;
    report();
  end

endmodule